// File: doc/BRIEF.md
# Single-Wire ROM Command Selector

This block is the network addressing layer of a slave on a single-wire bus. Each time the bit layer reports a completed reset/presence cycle, the block gathers one command byte, one bit per receive slot. It then runs the addressing function that the byte names against a fixed 64-bit identity set by parameters. When the device ends up selected, the block hands the bus to the memory function layer. When it does not, it goes quiet until the next reset.

The block never times the bus itself. It asks the bit layer for one slot at a time through a request/done handshake, and says whether the device sends a bit in that slot or samples the master's bit. It keeps two pieces of state across reset cycles:

- A resume flag, which lets a device that was previously addressed be selected again without its address.
- An overdrive flag, which goes out to the bit layer to choose the fast timing set.

Top module: `swr_rom_layer`

## Requirements
- R1: After `rst_n` is released and before the first `bus_reset_i` pulse, the block requests no slot. `mem_sel_o` and `od_o` are both 0.
- R2: After each `bus_reset_i` pulse, the block requests 8 receive slots (`slot_send_o`=0) and assembles the command byte least significant bit first. A pending request holds `slot_send_o` and `slot_tx_o` steady until `slot_done_i`.
- R3: Command 33h (read identity) produces 64 send slots carrying identity bits 0 to 63 in order, and then raises `mem_sel_o`. The identity places the family code in bits 7:0, the serial number in bits 55:8, and the check byte in bits 63:56.
- R4: Command 55h (match) requests 64 receive slots and compares each received bit with the identity bit of the same index. If all 64 match, `mem_sel_o` rises. At the first mismatch the block stops requesting slots and stays deselected until a bus reset.
- R5: Command F0h (search) runs 64 triplets: a send slot with the identity bit, a send slot with its complement, then a receive slot. A received bit that differs from the identity bit ends the search, and the block then idles until reset. A full pass selects the device.
- R6: Command CCh (skip) raises `mem_sel_o` with no further slot. While `mem_sel_o` is 1, the block requests no slot.
- R7: A fully successful 55h, F0h or 69h sets the resume flag. Commands 33h, CCh and 3Ch clear it, and so do failed 55h, F0h and 69h. Command A5h selects the device if the flag is set and idles otherwise, and leaves the flag unchanged.
- R8: Command 3Ch (overdrive skip) sets `od_o` and selects the device with no further slot.
- R9: Command 69h (overdrive match) sets `od_o` before its 64 receive slots. On a full match `od_o` stays 1 and the device is selected. On a mismatch `od_o` goes back to the value it had before the command.
- R10: `od_o` is cleared by a `bus_reset_i` pulse that has `reset_long_i`=1. A pulse with `reset_long_i`=0 leaves it unchanged.
- R11: Any other command byte leaves the block idle (no request, `mem_sel_o`=0) until the next bus reset, with both flags unchanged.
- R12: A `bus_reset_i` pulse in any state drops `mem_sel_o` and restarts command reception in the next cycle.
- R13: The identity's check byte is the CRC of its lower 56 bits under x^8+x^5+x^4+1, with the register cleared and the bits fed least significant first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_reset_i | input | 1 | One-cycle pulse: a reset/presence cycle has completed |
| reset_long_i | input | 1 | Qualifies `bus_reset_i`: the reset low time was of standard length |
| slot_req_o | output | 1 | Request for the next bit slot |
| slot_send_o | output | 1 | 1: the device sends `slot_tx_o` in the slot; 0: the device samples the master |
| slot_tx_o | output | 1 | Bit to send in a send slot (1 in receive slots) |
| slot_done_i | input | 1 | One-cycle pulse: the requested slot has finished |
| slot_rx_i | input | 1 | Bus value sampled in the finished slot |
| od_o | output | 1 | Overdrive flag: selects the fast timing set in the bit layer |
| mem_sel_o | output | 1 | Device selected; the memory function layer owns the bus until the next reset |

## Verification
The master-side checks themselves expose a wrong slot index or a wrong state. A shifted counter shows up within one slot as a wrong send bit, or as a wrong slot direction, in read identity and in search. A decode fault shows up as a missing or extra slot request in the cycle right after the eighth command bit. The resume and overdrive flags hold state across resets, so a corrupted flag stays invisible until a later command makes it visible. For that reason every sweep step ends with a probe such as resume, a short reset or a failed overdrive match, and the flag is checked at the ports within one bus reset.

// File: rtl/swr_rom_pkg.sv
// Shared definitions for the single-wire ROM command layer.
// Assumes identities are 64 bits sent least significant bit first.
package swr_rom_pkg;

    localparam int ID_BITS  = 64;
    localparam int CMD_BITS = 8;
    localparam logic [7:0] CRC_POLY_REFL = 8'h8C;

    localparam logic [7:0] OP_READ_ID  = 8'h33;
    localparam logic [7:0] OP_MATCH    = 8'h55;
    localparam logic [7:0] OP_SEARCH   = 8'hF0;
    localparam logic [7:0] OP_SKIP     = 8'hCC;
    localparam logic [7:0] OP_RESUME   = 8'hA5;
    localparam logic [7:0] OP_OD_SKIP  = 8'h3C;
    localparam logic [7:0] OP_OD_MATCH = 8'h69;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_TXID,
        ST_MATCH,
        ST_SRCH_TRUE,
        ST_SRCH_COMP,
        ST_SRCH_DIR,
        ST_SEL
    } rom_state_e;

    // Reflected CRC-8 (x^8+x^5+x^4+1) of 56 bits fed LSB first from zero.
    function automatic logic [7:0] id_crc8(input logic [55:0] d);
        logic [7:0] c;
        logic       fb;
        c = '0;
        for (int i = 0; i < 56; i++) begin
            fb = c[0] ^ d[i];
            c  = c >> 1;
            if (fb) c = c ^ CRC_POLY_REFL;
        end
        return c;
    endfunction

endpackage

// File: rtl/swr_id_source.sv
// Fixed identity: family, serial and computed check byte.
// Presents the identity bit at the given index; purely combinational.
module swr_id_source
    import swr_rom_pkg::*;
#(
    parameter logic [7:0]  FAMILY = 8'h23,
    parameter logic [47:0] SERIAL = 48'h0,
    parameter int          IDX_W  = 6
) (
    input  logic [IDX_W-1:0] idx_i,
    output logic             bit_o
);
    localparam logic [ID_BITS-1:0] IDENT = {id_crc8({SERIAL, FAMILY}), SERIAL, FAMILY};

    // Select one identity bit.
    always_comb bit_o = IDENT[idx_i];
endmodule

// File: rtl/swr_slot_counter.sv
// Slot index counter shared by command and identity phases.
// Assumes clear takes priority over step.
module swr_slot_counter #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         step_i,
    output logic [W-1:0] idx_o
);
    // Count completed slots within a phase.
    always_ff @(posedge clk) begin
        if (!rst_n)      idx_o <= '0;
        else if (clr_i)  idx_o <= '0;
        else if (step_i) idx_o <= idx_o + W'(1);
    end
endmodule

// File: rtl/swr_cmd_shift.sv
// Assembles the command byte, least significant bit first.
// next_o shows the byte including the bit being shifted now.
module swr_cmd_shift
    import swr_rom_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                shift_i,
    input  logic                bit_i,
    output logic [CMD_BITS-1:0] next_o
);
    logic [CMD_BITS-1:0] sr_q;

    // Byte view after the current bit enters at the top.
    always_comb next_o = {bit_i, sr_q[CMD_BITS-1:1]};

    // Shift one received bit per receive slot.
    always_ff @(posedge clk) begin
        if (!rst_n)       sr_q <= '0;
        else if (shift_i) sr_q <= next_o;
    end
endmodule

// File: rtl/swr_rom_layer.sv
// Network addressing layer of a single-wire slave.
// Assumes the bit layer pulses bus_reset_i once per reset/presence cycle and
// answers each slot request with exactly one slot_done_i pulse.
module swr_rom_layer
    import swr_rom_pkg::*;
#(
    parameter logic [7:0]  FAMILY = 8'h23,
    parameter logic [47:0] SERIAL = 48'h00_3E_A1_5C_07_D9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_reset_i,
    input  logic reset_long_i,
    output logic slot_req_o,
    output logic slot_send_o,
    output logic slot_tx_o,
    input  logic slot_done_i,
    input  logic slot_rx_i,
    output logic od_o,
    output logic mem_sel_o
);
    localparam int IDX_W = $clog2(ID_BITS);

    rom_state_e          state_q;
    logic                resume_q, od_q, od_entry_q, odm_q;
    logic [IDX_W-1:0]    idx;
    logic                id_bit, done, last_cmd, last_id, mism, step, clr;
    logic [CMD_BITS-1:0] cmd_next;

    swr_id_source #(.FAMILY(FAMILY), .SERIAL(SERIAL), .IDX_W(IDX_W)) u_id (
        .idx_i(idx), .bit_o(id_bit)
    );

    swr_slot_counter #(.W(IDX_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .step_i(step), .idx_o(idx)
    );

    swr_cmd_shift u_cmd (
        .clk(clk), .rst_n(rst_n), .shift_i(done && state_q == ST_CMD),
        .bit_i(slot_rx_i), .next_o(cmd_next)
    );

    // Slot completion and phase-end decode.
    always_comb begin
        done     = slot_done_i && slot_req_o;
        last_cmd = idx == IDX_W'(CMD_BITS - 1);
        last_id  = idx == IDX_W'(ID_BITS - 1);
        mism     = slot_rx_i != id_bit;
        clr      = bus_reset_i || (done && state_q == ST_CMD && last_cmd);
        step     = done && (state_q == ST_CMD || state_q == ST_TXID ||
                            state_q == ST_MATCH || state_q == ST_SRCH_DIR);
    end

    // Slot request outputs decoded from the state.
    always_comb begin
        slot_req_o  = 1'b0;
        slot_send_o = 1'b0;
        slot_tx_o   = 1'b1;
        case (state_q)
            ST_CMD, ST_MATCH, ST_SRCH_DIR: slot_req_o = 1'b1;
            ST_TXID, ST_SRCH_TRUE: begin
                slot_req_o  = 1'b1;
                slot_send_o = 1'b1;
                slot_tx_o   = id_bit;
            end
            ST_SRCH_COMP: begin
                slot_req_o  = 1'b1;
                slot_send_o = 1'b1;
                slot_tx_o   = ~id_bit;
            end
            default: ;
        endcase
        mem_sel_o = state_q == ST_SEL;
        od_o      = od_q;
    end

    // Command sequencing and flag upkeep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            resume_q   <= 1'b0;
            od_q       <= 1'b0;
            od_entry_q <= 1'b0;
            odm_q      <= 1'b0;
        end else if (bus_reset_i) begin
            state_q <= ST_CMD;
            if (reset_long_i) od_q <= 1'b0;
        end else if (done) begin
            case (state_q)
                ST_CMD: if (last_cmd) begin
                    case (cmd_next)
                        OP_READ_ID:  begin resume_q <= 1'b0; state_q <= ST_TXID; end
                        OP_MATCH:    begin resume_q <= 1'b0; odm_q <= 1'b0; state_q <= ST_MATCH; end
                        OP_SEARCH:   begin resume_q <= 1'b0; state_q <= ST_SRCH_TRUE; end
                        OP_SKIP:     begin resume_q <= 1'b0; state_q <= ST_SEL; end
                        OP_RESUME:   state_q <= resume_q ? ST_SEL : ST_IDLE;
                        OP_OD_SKIP:  begin resume_q <= 1'b0; od_q <= 1'b1; state_q <= ST_SEL; end
                        OP_OD_MATCH: begin
                            resume_q   <= 1'b0;
                            odm_q      <= 1'b1;
                            od_entry_q <= od_q;
                            od_q       <= 1'b1;
                            state_q    <= ST_MATCH;
                        end
                        default:     state_q <= ST_IDLE;
                    endcase
                end
                ST_TXID: if (last_id) state_q <= ST_SEL;
                ST_MATCH: begin
                    if (mism) begin
                        state_q <= ST_IDLE;
                        if (odm_q) od_q <= od_entry_q;
                    end else if (last_id) begin
                        resume_q <= 1'b1;
                        state_q  <= ST_SEL;
                    end
                end
                ST_SRCH_TRUE: state_q <= ST_SRCH_COMP;
                ST_SRCH_COMP: state_q <= ST_SRCH_DIR;
                ST_SRCH_DIR: begin
                    if (mism)         state_q <= ST_IDLE;
                    else if (last_id) begin
                        resume_q <= 1'b1;
                        state_q  <= ST_SEL;
                    end else          state_q <= ST_SRCH_TRUE;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/swr_rom_checker.sv
// Port-level properties of the ROM command layer, bound to the top module.
// Assumes synchronous active-low reset on rst_n.
module swr_rom_checker (
    input logic clk,
    input logic rst_n,
    input logic bus_reset_i,
    input logic reset_long_i,
    input logic slot_req_o,
    input logic slot_send_o,
    input logic slot_tx_o,
    input logic slot_done_i,
    input logic od_o,
    input logic mem_sel_o
);
    logic seen_q;

    // Remember whether any bus reset has arrived since rst_n.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= seen_q || bus_reset_i;
    end

    AST_QUIET_BEFORE_BUS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_q |-> (!slot_req_o && !mem_sel_o && !od_o)); // R1

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_req_o && !slot_done_i && !bus_reset_i) |=>
        (slot_req_o && $stable(slot_send_o) && $stable(slot_tx_o))); // R2

    AST_SEL_NO_SLOTS: assert property (@(posedge clk) disable iff (!rst_n)
        mem_sel_o |-> !slot_req_o); // R6

    AST_OD_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(od_o) |-> ($past(bus_reset_i && reset_long_i) ||
                         $past(slot_done_i && slot_req_o && !slot_send_o))); // R10

    AST_SHORT_RESET_KEEPS_OD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_reset_i && !reset_long_i && od_o) |=> od_o); // R10

    AST_RESET_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset_i |=> (slot_req_o && !slot_send_o && !mem_sel_o)); // R12

    AST_SEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_sel_o && !bus_reset_i) |=> mem_sel_o); // R12
endmodule

bind swr_rom_layer swr_rom_checker u_chk (
    .clk(clk), .rst_n(rst_n), .bus_reset_i(bus_reset_i), .reset_long_i(reset_long_i),
    .slot_req_o(slot_req_o), .slot_send_o(slot_send_o), .slot_tx_o(slot_tx_o),
    .slot_done_i(slot_done_i), .od_o(od_o), .mem_sel_o(mem_sel_o)
);

// File: tb/sim_swr_rom_layer.sv
// Bench: plays the bit layer and the master; sweeps every command byte and
// every mismatch position with expectations computed here.
module sim_swr_rom_layer;
    localparam logic [7:0]  FAM = 8'h23;
    localparam logic [47:0] SER = 48'h00_3E_A1_5C_07_D9;

    logic clk = 1'b0, rst_n = 1'b0;
    logic bus_reset_i = 1'b0, reset_long_i = 1'b0, slot_done_i = 1'b0, slot_rx_i = 1'b1;
    logic slot_req_o, slot_send_o, slot_tx_o, od_o, mem_sel_o;

    int nvec = 0, nfail = 0, cyc = 0;
    logic [63:0] exp_id;
    logic exp_res = 1'b0;

    always #5 clk = ~clk;

    swr_rom_layer #(.FAMILY(FAM), .SERIAL(SER)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_reset_i(bus_reset_i), .reset_long_i(reset_long_i),
        .slot_req_o(slot_req_o), .slot_send_o(slot_send_o), .slot_tx_o(slot_tx_o),
        .slot_done_i(slot_done_i), .slot_rx_i(slot_rx_i), .od_o(od_o), .mem_sel_o(mem_sel_o)
    );

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000) begin
            nfail = nfail + 1;
            $display("FAIL watchdog R12 act=%0d exp=<190000", cyc);
            $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic do_slot(input logic rx, output logic kind, output logic tx, output bit got);
        int w = 0;
        while (!slot_req_o && w < 40) begin @(negedge clk); w++; end
        got  = slot_req_o;
        kind = slot_send_o;
        tx   = slot_tx_o;
        if (got) begin
            slot_rx_i = rx; slot_done_i = 1'b1;
            @(negedge clk);
            slot_done_i = 1'b0; slot_rx_i = 1'b1;
        end
    endtask

    task automatic bus_rst(input logic lng);
        bus_reset_i = 1'b1; reset_long_i = lng;
        @(negedge clk);
        bus_reset_i = 1'b0; reset_long_i = 1'b0;
    endtask

    task automatic send_cmd(input logic [7:0] b, output bit ok);
        logic k, t; bit g;
        ok = 1'b1;
        for (int i = 0; i < 8; i++) begin
            do_slot(b[i], k, t, g);
            ok &= g && !k;
        end
    endtask

    task automatic rx_bits(input logic [63:0] pat, input int n, output bit allr, output bit odh);
        logic k, t; bit g;
        allr = 1'b1; odh = 1'b1;
        for (int i = 0; i < n; i++) begin
            odh &= od_o;
            do_slot(pat[i], k, t, g);
            allr &= g && !k;
        end
    endtask

    task automatic search_run(input int flip_at, output bit ok);
        logic k, t; bit g;
        ok = 1'b1;
        for (int i = 0; i < 64; i++) begin
            do_slot(1'b1, k, t, g); ok &= g && k && (t == exp_id[i]);
            do_slot(1'b1, k, t, g); ok &= g && k && (t == ~exp_id[i]);
            do_slot((i == flip_at) ? ~exp_id[i] : exp_id[i], k, t, g); ok &= g && !k;
            if (i == flip_at) break;
        end
    endtask

    task automatic idle_now(output bit q);
        repeat (4) @(negedge clk);
        q = !slot_req_o && !mem_sel_o;
    endtask

    initial begin
        logic [7:0] cn, crc;
        logic fb;
        logic [55:0] d;
        logic [63:0] rd;
        logic k, t;
        bit ok, ok2, g, q;
        // Bench CRC: non-reflected form (poly 31h) on the same bit stream, then bit-reversed.
        d = {SER, FAM}; cn = '0;
        for (int i = 0; i < 56; i++) begin
            fb = cn[7] ^ d[i];
            cn = {cn[6:0], 1'b0} ^ (fb ? 8'h31 : 8'h00);
        end
        for (int j = 0; j < 8; j++) crc[j] = cn[7-j];
        exp_id = {crc, SER, FAM};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        chk(!slot_req_o && !mem_sel_o && !od_o, "R1 quiet before bus reset",
            {61'b0, slot_req_o, mem_sel_o, od_o}, 64'h0);

        // Sweep every command byte.
        for (int c = 0; c < 256; c++) begin
            bus_rst(1'b1);
            chk(od_o == 1'b0 && slot_req_o && !slot_send_o, "R10/R12 long reset restarts, od cleared",
                {62'b0, od_o, slot_req_o}, 64'h1);
            send_cmd(8'(c), ok);
            chk(ok, "R2 command via 8 receive slots", c, c);
            case (8'(c))
                8'h33: begin
                    ok2 = 1'b1;
                    for (int i = 0; i < 64; i++) begin
                        do_slot(1'b1, k, t, g); ok2 &= g && k; rd[i] = t;
                    end
                    chk(ok2 && rd == exp_id, "R3 read identity bits", rd, exp_id);
                    chk(rd[63:56] == crc, "R13 check byte", rd[63:56], crc);
                    @(negedge clk);
                    chk(mem_sel_o, "R3 selected after read", mem_sel_o, 1);
                    exp_res = 1'b0;
                end
                8'h55: begin
                    rx_bits(exp_id, 64, ok2, q);
                    chk(ok2 && mem_sel_o && !slot_req_o, "R4 full match selects", mem_sel_o, 1);
                    exp_res = 1'b1;
                end
                8'hF0: begin
                    search_run(99, ok2);
                    chk(ok2 && mem_sel_o, "R5 full search selects", mem_sel_o, 1);
                    exp_res = 1'b1;
                end
                8'hCC: begin
                    chk(mem_sel_o && !slot_req_o, "R6 skip selects at once", mem_sel_o, 1);
                    exp_res = 1'b0;
                end
                8'hA5: begin
                    idle_now(q);
                    chk(mem_sel_o == exp_res, "R7 resume follows flag", mem_sel_o, exp_res);
                end
                8'h3C: begin
                    chk(mem_sel_o && od_o, "R8 overdrive skip", {mem_sel_o, od_o}, 2'b11);
                    exp_res = 1'b0;
                end
                8'h69: begin
                    rx_bits(exp_id, 64, ok2, q);
                    chk(ok2 && q && od_o && mem_sel_o, "R9 overdrive match", {ok2, q, od_o, mem_sel_o}, 4'hF);
                    exp_res = 1'b1;
                end
                default: begin
                    idle_now(q);
                    chk(q && !od_o, "R11 unknown command idles", {slot_req_o, mem_sel_o, od_o}, 0);
                end
            endcase
        end

        // Unknown command leaves the resume flag set.
        bus_rst(1'b1); send_cmd(8'h00, ok); bus_rst(1'b1); send_cmd(8'hA5, ok);
        chk(mem_sel_o == exp_res, "R11 flag kept across unknown command", mem_sel_o, exp_res);

        // Match mismatch at every bit position.
        for (int p = 0; p < 64; p++) begin
            bus_rst(1'b1); send_cmd(8'h55, ok);
            rx_bits(exp_id ^ (64'h1 << p), p + 1, ok2, q);
            idle_now(q);
            chk(ok2 && q, "R4 mismatch drops out", {slot_req_o, mem_sel_o}, 0);
        end
        bus_rst(1'b1); send_cmd(8'hA5, ok); idle_now(q);
        chk(q, "R7 failed match clears resume", mem_sel_o, 0);

        // Search dropout at every bit position.
        for (int p = 0; p < 64; p++) begin
            bus_rst(1'b1); send_cmd(8'hF0, ok);
            search_run(p, ok2);
            idle_now(q);
            chk(ok2 && q, "R5 search dropout", {slot_req_o, mem_sel_o}, 0);
        end

        // Resume after successful search, cleared by skip and read identity.
        bus_rst(1'b1); send_cmd(8'hF0, ok); search_run(99, ok2);
        bus_rst(1'b1); send_cmd(8'hA5, ok);
        chk(mem_sel_o, "R7 resume after search", mem_sel_o, 1);
        bus_rst(1'b1); send_cmd(8'hA5, ok);
        chk(mem_sel_o, "R7 resume leaves flag set", mem_sel_o, 1);
        bus_rst(1'b1); send_cmd(8'hCC, ok); bus_rst(1'b1); send_cmd(8'hA5, ok); idle_now(q);
        chk(q, "R7 skip clears resume", mem_sel_o, 0);

        // Overdrive flag life cycle.
        bus_rst(1'b1); send_cmd(8'h3C, ok);
        bus_rst(1'b0);
        chk(od_o, "R10 short reset keeps od", od_o, 1);
        send_cmd(8'hCC, ok);
        chk(od_o && mem_sel_o, "R10 od kept through skip", {od_o, mem_sel_o}, 2'b11);
        bus_rst(1'b0); send_cmd(8'h69, ok);
        rx_bits(exp_id ^ 64'h20, 6, ok2, q); idle_now(g);
        chk(od_o && g, "R9 failed od match keeps prior od=1", od_o, 1);
        bus_rst(1'b1);
        chk(!od_o, "R10 long reset clears od", od_o, 0);
        send_cmd(8'h69, ok);
        rx_bits(exp_id ^ 64'h20, 6, ok2, q); idle_now(g);
        chk(q && !od_o && g, "R9 failed od match restores od=0", {q, od_o}, 2'b10);

        // Reset aborts a sequence and a selection.
        bus_rst(1'b1); send_cmd(8'h33, ok);
        for (int i = 0; i < 10; i++) do_slot(1'b1, k, t, g);
        bus_rst(1'b0);
        chk(slot_req_o && !slot_send_o && !mem_sel_o, "R12 reset aborts read", {slot_req_o, slot_send_o}, 2'b10);
        send_cmd(8'hCC, ok);
        bus_rst(1'b0);
        chk(!mem_sel_o && slot_req_o, "R12 reset drops selection", mem_sel_o, 0);

        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule